// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronisation

This block is the timing reference for one pulse-width-modulation channel. A 16-bit counter, stepped by a tick that a two-stage prescaler derives from the system clock, runs up, down, up-and-down, or holds, against a period value. It reports when the count is at zero and when it is at the period, and it shows which way it is moving. The downstream compare and action logic uses these signals.

The period has two copies. The working copy sets the counter's turning point. The second copy is a staging copy that reaches the working copy only when the counter returns to zero, so a period change can land cleanly on a cycle boundary. Several instances can be daisy-chained. Each one loads a programmed phase offset when a sync pulse arrives from its neighbour or from a software force, and each one passes a chosen event on to the next instance in the chain.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count` is 0, `dir_up` is 1, `evt_zero`, `evt_prd` and `sync_out` are 0, and the working period is 0.
- R2: With `mode` = 0 (up), each tick adds one to `count` while it is below the working period. A tick at or above the period sets `count` to 0. `dir_up` is 1.
- R3: With `mode` = 1 (down), each tick subtracts one from `count`. A tick at 0 loads the working period. `dir_up` is 0.
- R4: With `mode` = 2 (up-down), `count` climbs to the period and then falls to 0, repeatedly. `dir_up` goes to 0 in the cycle `count` arrives at the period, goes to 1 in the cycle it arrives at 0, and otherwise shows the direction of the last step.
- R5: With `mode` = 3 (hold), `count` does not change except through a phase load.
- R6: A tick occurs once every H×C system cycles. H is 1 when `hs_div` is 0 and 2×`hs_div` otherwise. C is 2 to the power `clk_div`. `count` changes only on a tick or a phase load.
- R7: `evt_zero` is high for exactly the first cycle in which `count` shows 0 after a tick or phase load wrote it.
- R8: `evt_prd` is high for exactly the first cycle in which `count` equals the working period after a tick or phase load wrote it.
- R9: With `prd_buffered` = 0, a write with `prd_wr_en` puts `prd_wr_data` into the working period at that edge.
- R10: With `prd_buffered` = 1, a write goes only to the staging copy. The staging copy moves into the working period at the edge where `count` is written to 0.
- R11: `sync_in` and `force_sync` are registered into a sync event one cycle later. If `phase_en` is 1 during that event, `count` takes `phase_val` at the next edge, and this overrides counting. If `phase_en` is 0, the event does not change `count`.
- R12: `sync_sel` selects `sync_out`: 0 gives the registered sync event, 1 gives `evt_zero`, 2 gives `cmpb_match`, and 3 holds it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| prd_buffered | input | 1 | 1: period writes go through the staging copy |
| prd_wr_en | input | 1 | Period write strobe |
| prd_wr_data | input | 16 | Period write value |
| phase_en | input | 1 | Allow sync events to load the phase |
| phase_val | input | 16 | Phase value loaded on sync |
| sync_in | input | 1 | Sync pulse from the previous instance |
| force_sync | input | 1 | Software one-shot sync |
| cmpb_match | input | 1 | Compare-B equality from the compare stage |
| sync_sel | input | 2 | Sync output source select |
| hs_div | input | 3 | First prescaler stage code |
| clk_div | input | 3 | Second prescaler stage code |
| count | output | 16 | Counter value |
| dir_up | output | 1 | 1 while counting up |
| evt_zero | output | 1 | Count-at-zero strobe |
| evt_prd | output | 1 | Count-at-period strobe |
| sync_out | output | 1 | Sync pulse to the next instance |

## Verification
Some properties are checked on every cycle. Each strobe must agree with the count. The hold mode must keep the count. A phase load must land exactly one edge after the sync event. An up-count or down-wrap step must have the right value, the arrival at the up-down peak must be exact, and the disabled sync output must stay low. Other behaviour is shown only by the bench's scenarios, which compare against a cycle model on every clock. This covers the prescaler spacing across the divider codes, the timing of the staging-to-working period transfer, the direction flag at the turning points, and the ignored sync when phase loading is off.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CNT_W     = 16;
    localparam int HS_CODE_W = 3;
    localparam int CD_CODE_W = 3;
    localparam int HS_CNT_W  = HS_CODE_W + 1;
    localparam int CD_CNT_W  = (1 << CD_CODE_W) - 1;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_HOLD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SO_PASS = 2'd0,
        SO_ZERO = 2'd1,
        SO_CMPB = 2'd2,
        SO_OFF  = 2'd3
    } sync_src_e;

    typedef struct packed {
        logic             we;
        logic [CNT_W-1:0] nxt;
        logic             dir;
    } cnt_step_t;

    // last count value of the first stage: 0 -> /1, n -> /2n
    function automatic logic [HS_CNT_W-1:0] hs_limit(input logic [HS_CODE_W-1:0] code);
        logic [HS_CNT_W-1:0] dbl;
        dbl = {code, 1'b0};
        return (code == '0) ? '0 : dbl - HS_CNT_W'(1);
    endfunction

    // last count value of the second stage: k -> /2^k
    function automatic logic [CD_CNT_W-1:0] cd_limit(input logic [CD_CODE_W-1:0] code);
        logic [CD_CNT_W-1:0] one;
        one = CD_CNT_W'(1);
        return (one << code) - one;
    endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HS_CODE_W-1:0] hs_div,
    input  logic [CD_CODE_W-1:0] clk_div,
    output logic                 tick
);
    logic [HS_CNT_W-1:0] hs_q;
    logic [CD_CNT_W-1:0] cd_q;
    logic                hs_wrap;
    logic                cd_wrap;

    assign hs_wrap = (hs_q >= hs_limit(hs_div));
    assign cd_wrap = (cd_q >= cd_limit(clk_div));
    assign tick    = hs_wrap && cd_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= '0;
            cd_q <= '0;
        end else begin
            hs_q <= hs_wrap ? '0 : hs_q + HS_CNT_W'(1);
            if (hs_wrap)
                cd_q <= cd_wrap ? '0 : cd_q + CD_CNT_W'(1);
        end
    end
endmodule

// File: rtl/tbase_period.sv
module tbase_period #(
    parameter int                 W       = 16,
    parameter logic [W-1:0]       RST_PRD = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         buffered,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         at_zero_wr,
    output logic [W-1:0] prd_active
);
    logic [W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= RST_PRD;
            prd_active <= RST_PRD;
        end else begin
            if (wr_en)
                shadow_q <= wr_data;
            if (!buffered) begin
                if (wr_en)
                    prd_active <= wr_data;
            end else if (at_zero_wr) begin
                prd_active <= shadow_q;
            end
        end
    end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd,
    input  logic         load,
    input  logic [W-1:0] phase,
    output logic [W-1:0] count,
    output logic         dir_up,
    output logic         evt_zero,
    output logic         evt_prd,
    output logic         zero_wr
);
    logic [W-1:0] cnt_q;
    logic         dir_q;
    logic         upd_q;
    cnt_step_t    step;

    always_comb begin
        step.we  = 1'b0;
        step.nxt = cnt_q;
        step.dir = dir_q;
        if (load) begin
            step.we  = 1'b1;
            step.nxt = phase;
        end else if (tick) begin
            unique case (mode)
                MODE_UP: begin
                    step.we  = 1'b1;
                    step.nxt = (cnt_q >= prd) ? '0 : cnt_q + W'(1);
                end
                MODE_DOWN: begin
                    step.we  = 1'b1;
                    step.nxt = (cnt_q == '0) ? prd : cnt_q - W'(1);
                end
                MODE_UPDOWN: begin
                    step.we = 1'b1;
                    if (dir_q) begin
                        if (cnt_q >= prd)
                            step.nxt = (cnt_q == '0) ? '0 : cnt_q - W'(1);
                        else
                            step.nxt = cnt_q + W'(1);
                    end else begin
                        if (cnt_q == '0)
                            step.nxt = (prd == '0) ? '0 : W'(1);
                        else
                            step.nxt = cnt_q - W'(1);
                    end
                    if (step.nxt == '0)
                        step.dir = 1'b1;
                    else if (step.nxt >= prd)
                        step.dir = 1'b0;
                    else
                        step.dir = (step.nxt > cnt_q);
                end
                default: step.we = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
            upd_q <= 1'b0;
        end else begin
            upd_q <= step.we;
            if (step.we)
                cnt_q <= step.nxt;
            dir_q <= step.dir;
        end
    end

    assign count    = cnt_q;
    assign zero_wr  = step.we && (step.nxt == '0);
    assign evt_zero = upd_q && (cnt_q == '0);
    assign evt_prd  = upd_q && (cnt_q == prd);

    always_comb begin
        unique case (mode)
            MODE_UP:   dir_up = 1'b1;
            MODE_DOWN: dir_up = 1'b0;
            default:   dir_up = dir_q;
        endcase
    end
endmodule

// File: rtl/tbase_sync.sv
module tbase_sync
    import tbase_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_in,
    input  logic      force_sync,
    input  logic      evt_zero,
    input  logic      cmpb_match,
    input  sync_src_e sel,
    output logic      sync_evt,
    output logic      sync_out
);
    always_ff @(posedge clk) begin
        if (rst) sync_evt <= 1'b0;
        else     sync_evt <= sync_in || force_sync;
    end

    always_comb begin
        unique case (sel)
            SO_PASS: sync_out = sync_evt;
            SO_ZERO: sync_out = evt_zero;
            SO_CMPB: sync_out = cmpb_match;
            default: sync_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import tbase_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode,
    input  logic                 prd_buffered,
    input  logic                 prd_wr_en,
    input  logic [W-1:0]         prd_wr_data,
    input  logic                 phase_en,
    input  logic [W-1:0]         phase_val,
    input  logic                 sync_in,
    input  logic                 force_sync,
    input  logic                 cmpb_match,
    input  logic [1:0]           sync_sel,
    input  logic [HS_CODE_W-1:0] hs_div,
    input  logic [CD_CODE_W-1:0] clk_div,
    output logic [W-1:0]         count,
    output logic                 dir_up,
    output logic                 evt_zero,
    output logic                 evt_prd,
    output logic                 sync_out
);
    logic         tick;
    logic         sync_evt;
    logic         phase_load;
    logic         zero_wr;
    logic [W-1:0] prd_active;

    assign phase_load = sync_evt && phase_en;

    tbase_prescaler u_pre (
        .clk(clk), .rst(rst), .hs_div(hs_div), .clk_div(clk_div), .tick(tick)
    );

    tbase_period #(.W(W)) u_prd (
        .clk(clk), .rst(rst), .buffered(prd_buffered), .wr_en(prd_wr_en),
        .wr_data(prd_wr_data), .at_zero_wr(zero_wr), .prd_active(prd_active)
    );

    tbase_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .mode(cnt_mode_e'(mode)),
        .prd(prd_active), .load(phase_load), .phase(phase_val),
        .count(count), .dir_up(dir_up), .evt_zero(evt_zero),
        .evt_prd(evt_prd), .zero_wr(zero_wr)
    );

    tbase_sync u_sync (
        .clk(clk), .rst(rst), .sync_in(sync_in), .force_sync(force_sync),
        .evt_zero(evt_zero), .cmpb_match(cmpb_match),
        .sel(sync_src_e'(sync_sel)), .sync_evt(sync_evt), .sync_out(sync_out)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic         tick,
    input logic         load,
    input logic [W-1:0] count,
    input logic [W-1:0] prd_active,
    input logic [W-1:0] phase_val,
    input logic         evt_zero,
    input logic         evt_prd,
    input logic [1:0]   sync_sel,
    input logic         sync_out
);
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        evt_zero |-> count == '0);  // R7
    AST_PRD_MATCH: assert property (@(posedge clk) disable iff (rst)
        evt_prd |-> count == prd_active);  // R8
    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(phase_val));  // R11
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && !load) |=> count == $past(count));  // R5
    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && tick && !load && count < prd_active)
        |=> count == $past(count) + W'(1));  // R2
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && tick && !load && count == '0)
        |=> count == $past(prd_active));  // R3
    AST_UPDOWN_PEAK: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && tick && !load && count < prd_active
         && count + W'(1) == prd_active && $past(count) < count)
        |=> count == $past(prd_active));  // R4
    AST_SYNC_OFF: assert property (@(posedge clk) disable iff (rst)
        sync_sel == 2'd3 |-> !sync_out);  // R12
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .tick(tick), .load(phase_load),
    .count(count), .prd_active(prd_active), .phase_val(phase_val),
    .evt_zero(evt_zero), .evt_prd(evt_prd), .sync_sel(sync_sel),
    .sync_out(sync_out)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        prd_buffered = 1'b0;
    logic        prd_wr_en = 1'b0;
    logic [15:0] prd_wr_data = '0;
    logic        phase_en = 1'b0;
    logic [15:0] phase_val = '0;
    logic        sync_in = 1'b0;
    logic        force_sync = 1'b0;
    logic        cmpb_match = 1'b0;
    logic [1:0]  sync_sel = 2'd0;
    logic [2:0]  hs_div = '0;
    logic [2:0]  clk_div = '0;
    logic [15:0] count;
    logic        dir_up, evt_zero, evt_prd, sync_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_hs, m_cd, m_cnt, m_act, m_sh;
    bit m_dir, m_upd, m_sq;

    always #10 clk = ~clk;

    pwm_timebase u_dut (
        .clk(clk), .rst(rst), .mode(mode), .prd_buffered(prd_buffered),
        .prd_wr_en(prd_wr_en), .prd_wr_data(prd_wr_data), .phase_en(phase_en),
        .phase_val(phase_val), .sync_in(sync_in), .force_sync(force_sync),
        .cmpb_match(cmpb_match), .sync_sel(sync_sel), .hs_div(hs_div),
        .clk_div(clk_div), .count(count), .dir_up(dir_up), .evt_zero(evt_zero),
        .evt_prd(evt_prd), .sync_out(sync_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_hs = 0; m_cd = 0; m_cnt = 0; m_act = 0; m_sh = 0;
            m_dir = 1; m_upd = 0; m_sq = 0;
        end else begin
            int hsr, cdr, nxt;
            bit tk, ld, we, nd;
            hsr = (hs_div == 0) ? 1 : 2 * hs_div;
            cdr = 1 << clk_div;
            tk = (m_hs == hsr - 1 || m_hs >= hsr) && (m_cd >= cdr - 1);
            if (m_hs >= hsr - 1) begin
                m_hs = 0;
                m_cd = (m_cd >= cdr - 1) ? 0 : m_cd + 1;
            end else m_hs++;
            ld = m_sq && phase_en;
            we = 0; nxt = m_cnt; nd = m_dir;
            if (ld) begin we = 1; nxt = phase_val; end
            else if (tk && mode != 3) begin
                we = 1;
                if (mode == 0) nxt = (m_cnt >= m_act) ? 0 : m_cnt + 1;
                else if (mode == 1) nxt = (m_cnt == 0) ? m_act : m_cnt - 1;
                else begin
                    if (m_dir) nxt = (m_cnt >= m_act) ? (m_cnt == 0 ? 0 : m_cnt - 1) : m_cnt + 1;
                    else       nxt = (m_cnt == 0) ? (m_act == 0 ? 0 : 1) : m_cnt - 1;
                    if (nxt == 0) nd = 1;
                    else if (nxt >= m_act) nd = 0;
                    else nd = (nxt > m_cnt);
                end
            end
            if (prd_buffered) begin
                if (we && nxt == 0) m_act = m_sh;
            end else if (prd_wr_en) m_act = prd_wr_data;
            if (prd_wr_en) m_sh = prd_wr_data;
            m_upd = we;
            if (we) m_cnt = nxt;
            m_dir = nd;
            m_sq = sync_in || force_sync;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_dir, e_z, e_p, e_so;
            e_dir = (mode == 0) ? 1 : (mode == 1) ? 0 : m_dir;
            e_z = m_upd && m_cnt == 0;
            e_p = m_upd && m_cnt == m_act;
            case (sync_sel)
                2'd0: e_so = m_sq;
                2'd1: e_so = e_z;
                2'd2: e_so = cmpb_match;
                default: e_so = 0;
            endcase
            chk(cur_req, "count", count, m_cnt);
            chk("R4", "dir_up", dir_up, e_dir);
            chk("R7", "evt_zero", evt_zero, e_z);
            chk("R8", "evt_prd", evt_prd, e_p);
            chk("R12", "sync_out", sync_out, e_so);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    task automatic wr_prd(input int v);
        prd_wr_en = 1; prd_wr_data = 16'(v); cyc(1); prd_wr_en = 0;
    endtask

    task automatic pulse_sync(input bit frc);
        if (frc) force_sync = 1; else sync_in = 1;
        cyc(1); force_sync = 0; sync_in = 0;
    endtask

    initial begin
        cyc(3);
        // R1: reset state observed while reset is held
        @(negedge clk);
        chk("R1", "count", count, 0);
        chk("R1", "dir_up", dir_up, 1);
        chk("R1", "evt_zero", evt_zero, 0);
        chk("R1", "evt_prd", evt_prd, 0);
        chk("R1", "sync_out", sync_out, 0);
        #2 rst = 0;
        cur_req = "R9"; wr_prd(5); cyc(3);
        cur_req = "R2"; cyc(20);
        cur_req = "R3"; mode = 1; cyc(20);
        cur_req = "R4"; mode = 2; cyc(30);
        wr_prd(1); cyc(10); wr_prd(4);
        cur_req = "R5"; mode = 3; cyc(12);
        cur_req = "R6"; mode = 0; hs_div = 3; clk_div = 2; cyc(200);
        hs_div = 1; clk_div = 0; cyc(40);
        mode = 2; hs_div = 7; clk_div = 7; wr_prd(2); cyc(9000);
        hs_div = 0; clk_div = 0; mode = 0;
        cur_req = "R10"; prd_buffered = 1; cyc(2); wr_prd(9); cyc(30);
        wr_prd(3); cyc(4); wr_prd(6); cyc(30);
        mode = 1; wr_prd(2); cyc(20);
        prd_buffered = 0; mode = 0; wr_prd(7);
        cur_req = "R11"; phase_en = 1; phase_val = 4;
        sync_sel = 0; pulse_sync(0); cyc(5);
        phase_val = 6; pulse_sync(1); cyc(5);
        phase_en = 0; phase_val = 1; pulse_sync(0); cyc(4); pulse_sync(1); cyc(4);
        phase_en = 1; phase_val = 2; hs_div = 2; mode = 2; cyc(3); pulse_sync(0); cyc(20);
        hs_div = 0; mode = 0;
        cur_req = "R12";
        sync_sel = 1; cyc(20);
        sync_sel = 2; cmpb_match = 1; cyc(2); cmpb_match = 0; cyc(2);
        cmpb_match = 1; cyc(1); cmpb_match = 0;
        sync_sel = 3; pulse_sync(0); cmpb_match = 1; cyc(10); cmpb_match = 0;
        sync_sel = 0; phase_en = 0; pulse_sync(1); cyc(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule